// File: doc/BRIEF.md
# Programmed-I/O Strobe Timing Generator

This block sequences one programmed-I/O transfer on a disk channel. A transfer has three phases. First the address is held valid for a setup interval. Then a read or a write strobe is driven for a minimum active width. Last comes a recovery interval in which both the address and the strobe are released. Each of four drives (two channels with two drives each) has its own setup, active and recovery counts. Every count is coded as its clock length minus one.

A requester presents a drive index and a direction while the block is idle. The block accepts the request and copies the selected drive's counts. From then on it runs the transfer on its own and ignores all inputs except the device ready line and the read data bus. The device may hold ready low at the end of the minimum active width to stretch the strobe. An optional limit stops such stretching and flags an error. On a read, the data bus is captured on the last strobe clock. A single-clock done pulse marks the last recovery clock.

Top module: `pio_strobe_gen`

## Requirements
- R1: After reset, addr_valid, rd_strobe, wr_strobe, done and err are low, req_ready is high and rd_data_out is zero.
- R2: For drive d (0..3), the setup code is setup_byte[2d+1:2d], the active code is tim_word[8d+7:8d+4] and the recovery code is tim_word[8d+3:8d]. Each phase lasts its code plus one clocks. Codes of other drives have no effect.
- R3: A request is accepted at a clock edge where req_valid and req_ready are both high. From the next clock, addr_valid is high through the setup and active phases. rd_strobe (req_write=0) or wr_strobe (req_write=1) is high only in the active phase. Recovery has addr_valid and both strobes low.
- R4: With dev_ready high, the strobe lasts exactly active code plus one clocks. It is directly preceded by setup code plus one clocks and followed by recovery code plus one clocks.
- R5: done is high for exactly one clock, the last recovery clock. req_ready is low from acceptance until done and high again in the clock after done.
- R6: dev_ready is examined only on the last clock of the minimum active width and on the clocks after it. Each such clock with dev_ready low adds one strobe clock. The strobe ends on the first such clock with dev_ready high.
- R7: The 2-bit wait_lim code selects the maximum number of added strobe clocks: 0 = unlimited, 1 = 64, 2 = 128, 3 = 192. When the limit is reached, the strobe ends and err goes high. err stays high until the next request is accepted, which clears it.
- R8: On a read, rd_data_out takes the value rd_data_in has during the last strobe clock. Values present on earlier strobe clocks are not kept. A write leaves rd_data_out unchanged.
- R9: tim_word, setup_byte, wait_lim, req_drive and req_write are sampled only at acceptance. Changing them during a transfer does not change that transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tim_word | input | 32 | Active and recovery codes, one byte per drive |
| setup_byte | input | 8 | Setup codes, two bits per drive |
| wait_lim | input | 2 | Ready-wait extension limit code |
| req_valid | input | 1 | Transfer request |
| req_drive | input | 2 | Drive index of the request |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_ready | output | 1 | Idle, request can be accepted |
| dev_ready | input | 1 | Device ready, low stretches the strobe |
| rd_data_in | input | 16 | Device read data |
| rd_data_out | output | 16 | Captured read data |
| addr_valid | output | 1 | Address phase active (setup and strobe) |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| done | output | 1 | One-clock pulse on the last recovery clock |
| err | output | 1 | Ready-wait limit was reached in the last transfer |

## Verification
The assertions check on every cycle the phase ordering of the outputs. A strobe never appears without a valid address. An accepted request always opens with a strobe-free setup clock. Each strobe is followed by a released bus. done never lasts two clocks. err rises only as a strobe ends and falls only at acceptance. The exact phase lengths per drive, the choice of the right field among the four, the stretch counts, the three limit values and the clock on which read data is caught depend on programmed values. Only the bench's sweeps can show those, by counting clocks against codes computed from the requirements.

// File: rtl/pio_pkg.sv
package pio_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_ACT   = 2'd2,
        PH_REC   = 2'd3
    } pio_phase_e;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pio_field_sel.sv
module pio_field_sel #(
    parameter int DRIVES = 4,
    parameter int SET_W  = 2,
    parameter int ACT_W  = 4,
    parameter int REC_W  = 4,
    localparam int DRV_W = (DRIVES > 1) ? $clog2(DRIVES) : 1,
    localparam int FLD_W = ACT_W + REC_W
) (
    input  logic [DRIVES*FLD_W-1:0] tim_word,
    input  logic [DRIVES*SET_W-1:0] setup_byte,
    input  logic [DRV_W-1:0]        drive_sel,
    output logic [SET_W-1:0]        set_code,
    output logic [ACT_W-1:0]        act_code,
    output logic [REC_W-1:0]        rec_code
);

    logic [SET_W-1:0] set_arr [DRIVES];
    logic [ACT_W-1:0] act_arr [DRIVES];
    logic [REC_W-1:0] rec_arr [DRIVES];

    for (genvar g = 0; g < DRIVES; g++) begin : g_drive
        assign set_arr[g] = setup_byte[g*SET_W +: SET_W];
        assign rec_arr[g] = tim_word[g*FLD_W +: REC_W];
        assign act_arr[g] = tim_word[g*FLD_W+REC_W +: ACT_W];
    end

    assign set_code = set_arr[drive_sel];
    assign act_code = act_arr[drive_sel];
    assign rec_code = rec_arr[drive_sel];

endmodule

// File: rtl/pio_wait_limit.sv
module pio_wait_limit #(
    parameter int LIM_W     = 2,
    parameter int WAIT_STEP = 64,
    localparam int WCNT_W   = $clog2(WAIT_STEP*((1 << LIM_W) - 1) + 1)
) (
    input  logic [LIM_W-1:0]  lim_code,
    output logic              lim_en,
    output logic [WCNT_W-1:0] lim_val
);

    assign lim_en  = (lim_code != '0);
    assign lim_val = WCNT_W'(WAIT_STEP) * WCNT_W'(lim_code);

endmodule

// File: rtl/pio_phase_seq.sv
module pio_phase_seq
    import pio_pkg::*;
#(
    parameter int SET_W  = 2,
    parameter int ACT_W  = 4,
    parameter int REC_W  = 4,
    parameter int WCNT_W = 8,
    parameter int DATA_W = 16,
    localparam int CNT_W = max3(SET_W, ACT_W, REC_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [SET_W-1:0]  set_code,
    input  logic [ACT_W-1:0]  act_code,
    input  logic [REC_W-1:0]  rec_code,
    input  logic              lim_en,
    input  logic [WCNT_W-1:0] lim_val,
    input  logic              dev_ready,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic              idle,
    output logic              addr_valid,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data_out
);

    typedef struct packed {
        pio_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [WCNT_W-1:0] wcnt;
        logic              wr;
        logic              err;
        logic [ACT_W-1:0]  act;
        logic [REC_W-1:0]  rec;
        logic              lim_en;
        logic [WCNT_W-1:0] lim;
        logic [DATA_W-1:0] rdata;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    cnt_zero_q;

    assign cnt_zero_q = (st_q.cnt == '0);

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase  = PH_SETUP;
                    st_d.cnt    = CNT_W'(set_code);
                    st_d.wcnt   = '0;
                    st_d.wr     = start_wr;
                    st_d.err    = 1'b0;
                    st_d.act    = act_code;
                    st_d.rec    = rec_code;
                    st_d.lim_en = lim_en;
                    st_d.lim    = lim_val;
                end
            end
            PH_SETUP: begin
                if (cnt_zero_q) begin
                    st_d.phase = PH_ACT;
                    st_d.cnt   = CNT_W'(st_q.act);
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            PH_ACT: begin
                if (!cnt_zero_q) begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end else if (dev_ready || (st_q.lim_en && st_q.wcnt == st_q.lim)) begin
                    st_d.phase = PH_REC;
                    st_d.cnt   = CNT_W'(st_q.rec);
                    st_d.err   = !dev_ready;
                    if (!st_q.wr) begin
                        st_d.rdata = rd_data_in;
                    end
                end else begin
                    st_d.wcnt = st_q.wcnt + WCNT_W'(1);
                end
            end
            PH_REC: begin
                if (cnt_zero_q) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idle        = (st_q.phase == PH_IDLE);
    assign addr_valid  = (st_q.phase == PH_SETUP) || (st_q.phase == PH_ACT);
    assign rd_strobe   = (st_q.phase == PH_ACT) && !st_q.wr;
    assign wr_strobe   = (st_q.phase == PH_ACT) && st_q.wr;
    assign done        = (st_q.phase == PH_REC) && cnt_zero_q;
    assign err         = st_q.err;
    assign rd_data_out = st_q.rdata;

endmodule

// File: rtl/pio_strobe_gen.sv
module pio_strobe_gen
    import pio_pkg::*;
#(
    parameter int DRIVES    = 4,
    parameter int SET_W     = 2,
    parameter int ACT_W     = 4,
    parameter int REC_W     = 4,
    parameter int LIM_W     = 2,
    parameter int WAIT_STEP = 64,
    parameter int DATA_W    = 16,
    localparam int DRV_W    = (DRIVES > 1) ? $clog2(DRIVES) : 1,
    localparam int TIM_W    = DRIVES * (ACT_W + REC_W),
    localparam int SETB_W   = DRIVES * SET_W,
    localparam int WCNT_W   = $clog2(WAIT_STEP*((1 << LIM_W) - 1) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  tim_word,
    input  logic [SETB_W-1:0] setup_byte,
    input  logic [LIM_W-1:0]  wait_lim,
    input  logic              req_valid,
    input  logic [DRV_W-1:0]  req_drive,
    input  logic              req_write,
    output logic              req_ready,
    input  logic              dev_ready,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic [DATA_W-1:0] rd_data_out,
    output logic              addr_valid,
    output logic              rd_strobe,
    output logic              wr_strobe,
    output logic              done,
    output logic              err
);

    logic [SET_W-1:0]  sel_set;
    logic [ACT_W-1:0]  sel_act;
    logic [REC_W-1:0]  sel_rec;
    logic              lim_en;
    logic [WCNT_W-1:0] lim_val;
    logic              idle;

    pio_field_sel #(
        .DRIVES(DRIVES), .SET_W(SET_W), .ACT_W(ACT_W), .REC_W(REC_W)
    ) u_sel (
        .tim_word   (tim_word),
        .setup_byte (setup_byte),
        .drive_sel  (req_drive),
        .set_code   (sel_set),
        .act_code   (sel_act),
        .rec_code   (sel_rec)
    );

    pio_wait_limit #(
        .LIM_W(LIM_W), .WAIT_STEP(WAIT_STEP)
    ) u_lim (
        .lim_code (wait_lim),
        .lim_en   (lim_en),
        .lim_val  (lim_val)
    );

    pio_phase_seq #(
        .SET_W(SET_W), .ACT_W(ACT_W), .REC_W(REC_W),
        .WCNT_W(WCNT_W), .DATA_W(DATA_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (req_valid),
        .start_wr    (req_write),
        .set_code    (sel_set),
        .act_code    (sel_act),
        .rec_code    (sel_rec),
        .lim_en      (lim_en),
        .lim_val     (lim_val),
        .dev_ready   (dev_ready),
        .rd_data_in  (rd_data_in),
        .idle        (idle),
        .addr_valid  (addr_valid),
        .rd_strobe   (rd_strobe),
        .wr_strobe   (wr_strobe),
        .done        (done),
        .err         (err),
        .rd_data_out (rd_data_out)
    );

    assign req_ready = idle;

endmodule

// File: rtl/pio_strobe_gen_chk.sv
module pio_strobe_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic addr_valid,
    input logic rd_strobe,
    input logic wr_strobe,
    input logic done,
    input logic err
);

    // R3
    strobe_needs_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe || wr_strobe) |-> addr_valid);

    // R3
    accept_opens_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (addr_valid && !rd_strobe && !wr_strobe && !req_ready));

    // R3
    strobe_end_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_strobe) || $fell(wr_strobe)) |-> (!addr_valid && !req_ready));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

    // R5
    done_in_recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!addr_valid && !req_ready));

    // R7
    err_rise_at_strobe_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($fell(rd_strobe) || $fell(wr_strobe)));

    // R7
    err_clear_at_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(req_valid && req_ready));

    // R3
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({rd_strobe, wr_strobe}) <= 1);

endmodule

bind pio_strobe_gen pio_strobe_gen_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .addr_valid (addr_valid),
    .rd_strobe  (rd_strobe),
    .wr_strobe  (wr_strobe),
    .done       (done),
    .err        (err)
);

// File: tb/pio_strobe_gen_tb.sv
module pio_strobe_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tim_word = '0;
    logic [7:0]  setup_byte = '0;
    logic [1:0]  wait_lim = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_drive = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic        dev_ready = 1'b1;
    logic [15:0] rd_data_in = '0;
    logic [15:0] rd_data_out;
    logic        addr_valid, rd_strobe, wr_strobe, done, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 1'b0;

    pio_strobe_gen dut_i (
        .clk(clk), .rst_n(rst_n), .tim_word(tim_word), .setup_byte(setup_byte),
        .wait_lim(wait_lim), .req_valid(req_valid), .req_drive(req_drive),
        .req_write(req_write), .req_ready(req_ready), .dev_ready(dev_ready),
        .rd_data_in(rd_data_in), .rd_data_out(rd_data_out), .addr_valid(addr_valid),
        .rd_strobe(rd_strobe), .wr_strobe(wr_strobe), .done(done), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG && !finished) begin
            finished = 1'b1;
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One transfer. ext: strobe clocks added by holding ready low (0 = ready high,
    // large = never raised). exp_ext / exp_err: expected stretch and error.
    task automatic run(input int d, input bit w, input int s, input int a, input int r,
                       input int lim, input int ext, input bit scramble,
                       input int exp_ext, input bit exp_err);
        int sc = 0, ac = 0, rc = 0, wrong = 0, busy_bad = 0, n = 0;
        int base;
        logic [15:0] prev;
        logic [15:0] exp_data;
        for (int i = 0; i < 4; i++) begin
            if (i == d) begin
                tim_word[8*i +: 8]   = 8'((a << 4) | r);
                setup_byte[2*i +: 2] = 2'(s);
            end else begin
                tim_word[8*i +: 8]   = 8'((((a + 7) & 15) << 4) | ((r + 9) & 15));
                setup_byte[2*i +: 2] = 2'((s + 1) & 3);
            end
        end
        base       = (d * 4096 + s * 256 + a * 16 + r + (w ? 0 : 7)) & 16'hffff;
        wait_lim   = 2'(lim);
        req_drive  = 2'(d);
        req_write  = w;
        dev_ready  = (ext == 0);
        rd_data_in = 16'(base);
        prev       = rd_data_out;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        // R7: error cleared by acceptance
        chk(err == 1'b0, "R7 err cleared at accept", int'(err), 0);
        while (n < 2000) begin
            if (scramble && n == 0) begin
                // R9: change every sampled input mid-transfer
                tim_word   = ~tim_word;
                setup_byte = ~setup_byte;
                req_write  = ~req_write;
                req_drive  = req_drive + 2'd1;
                wait_lim   = ~wait_lim;
            end
            if (addr_valid && !rd_strobe && !wr_strobe) sc++;
            if (rd_strobe || wr_strobe) begin
                ac++;
                if (wr_strobe != w || rd_strobe == w) wrong++;
                rd_data_in = 16'(base + ac);
                if (ext > 0 && ac == a + 1 + ext) dev_ready = 1'b1;
            end
            if (!addr_valid && !rd_strobe && !wr_strobe) rc++;
            if (req_ready) busy_bad++;
            if (done) break;
            n++;
            @(negedge clk);
        end
        chk(sc == s + 1, "R2 R4 setup length", sc, s + 1);
        chk(ac == a + 1 + exp_ext, "R2 R4 R6 R7 strobe length", ac, a + 1 + exp_ext);
        chk(rc == r + 1, "R2 R4 recovery length", rc, r + 1);
        chk(wrong == 0, "R3 strobe kind", wrong, 0);
        chk(busy_bad == 0, "R5 busy during transfer", busy_bad, 0);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R5 done single and ready after",
            int'({done, req_ready}), 1);
        chk(err == exp_err, "R7 err flag", int'(err), int'(exp_err));
        exp_data = w ? prev : 16'(base + a + 1 + exp_ext);
        chk(rd_data_out == exp_data, "R8 read capture", int'(rd_data_out), int'(exp_data));
        dev_ready = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        chk({addr_valid, rd_strobe, wr_strobe, done, err} == 5'b0, "R1 outputs low",
            int'({addr_valid, rd_strobe, wr_strobe, done, err}), 0);
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rd_data_out == 16'h0, "R1 data", int'(rd_data_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && addr_valid == 1'b0, "R1 idle after release",
            int'({req_ready, addr_valid}), 2);

        // R2 R3 R4 R5 R8: sweep over drives, codes and direction
        for (int d = 0; d < 4; d++)
            for (int s = 0; s < 4; s++)
                for (int ai = 0; ai < 3; ai++)
                    for (int ri = 0; ri < 3; ri++)
                        for (int w = 0; w < 2; w++)
                            run(d, w[0], s, (ai == 0) ? 0 : (ai == 1) ? 5 : 15,
                                (ri == 0) ? 0 : (ri == 1) ? 7 : 15, 0, 0, 1'b0, 0, 1'b0);

        // R6: stretched strobes, unlimited
        for (int k = 1; k < 25; k += 6) begin
            run(1, 1'b0, 1, 3, 2, 0, k, 1'b0, k, 1'b0);
            run(2, 1'b1, 0, 0, 1, 0, k, 1'b0, k, 1'b0);
        end
        run(3, 1'b0, 2, 4, 3, 0, 200, 1'b0, 200, 1'b0);
        // R6 with a limit set but not reached
        run(0, 1'b0, 1, 2, 1, 1, 63, 1'b0, 63, 1'b0);

        // R7: each limit value reached with ready held low
        for (int l = 1; l < 4; l++) begin
            run(l, 1'b0, 1, 2, 3, l, 100000, 1'b0, 64 * l, 1'b1);
            // next transfer clears the flag
            run(l, 1'b1, 0, 1, 0, 0, 0, 1'b0, 0, 1'b0);
        end

        // R9: inputs changed during transfer
        for (int d = 0; d < 4; d++) begin
            run(d, 1'b0, 3, 9, 4, 1, 0, 1'b1, 0, 1'b0);
            run(d, 1'b1, 0, 2, 11, 0, 0, 1'b1, 0, 1'b0);
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule